// File: doc/BRIEF.md
# Single-Master Address-Decoding Fabric with Fixed Wait States

This block sits between one memory-mapped master and two slaves. It compares the master's word address against a window for each slave. It raises the select of the slave whose window contains the address and hands that slave the address as an offset from its window base. Slaves therefore decode nothing. Write data reaches only the selected slave. Read data comes back from the selected slave only.

The fabric stretches each transfer with a fixed number of stall cycles, driven on `m_wait`. The count is configured per slave and separately for reads and writes. A read or write is taken in the first cycle in which the master strobe is high and `m_wait` is low. The master must hold its address, data and strobes steady while `m_wait` is high.

Reads are pipelined. Every slave returns data a fixed `RD_LAT` cycles after the read is taken, so a master can issue reads back to back without waiting. The fabric marks each returning datum with `m_rdv` and keeps issue order. An access that hits no window is taken at once and reaches no slave; a read of that kind returns zero.

The reset is asynchronous and active low. It is expected to be released in step with `clk`.

Top module: `mmx_fabric`

## Requirements
- R1: `slv_sel[i]` is high exactly when `m_addr` lies in window i. Window i is 2^SZ[i] words starting at BASE[i], and BASE[i] is a multiple of 2^SZ[i]. `slv_rd[i]` and `slv_wr[i]` copy `m_read` and `m_write` only while `slv_sel[i]` is high. At most one select is high at a time.
- R2: Slot i of `slv_addr` (bits i*ADDR_W and up) carries `m_addr - BASE[i]` while slave i is selected.
- R3: Slot i of `slv_wdata` carries `m_wdata` while slave i is selected and is zero otherwise.
- R4: A read of slave i taken in cycle c returns, in cycle c+RD_LAT, the value slave i drives on its `slv_rdata` slot in that cycle.
- R5: For a read of slave i, `m_wait` is high for exactly RD_WAIT[i] cycles and then low for the cycle in which the read is taken. For a write, the count is WR_WAIT[i]. A new transfer right after a taken one pays its full count again.
- R6: A read taken in cycle c raises `m_rdv` for exactly one cycle, cycle c+RD_LAT. With zero read wait, reads can be taken on consecutive cycles, and their data return on consecutive cycles in issue order.
- R7: `m_rdata` is zero in every cycle in which `m_rdv` is low.
- R8: An access outside every window is never stalled, raises no select and no slave strobe, and gives every `slv_wdata` slot the value zero. A read of that kind returns zero data with `m_rdv` after RD_LAT cycles.
- R9: While reset is asserted, `m_rdv` is low and `m_rdata` is zero. Reads in flight when reset arrives never return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | ADDR_W | Master word address |
| m_read | input | 1 | Master read strobe |
| m_write | input | 1 | Master write strobe |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Read data to master, zero when not valid |
| m_wait | output | 1 | Stall: hold the transfer steady |
| m_rdv | output | 1 | Read data valid, one cycle per read |
| slv_sel | output | NS | One select per slave |
| slv_rd | output | NS | Read strobe per slave |
| slv_wr | output | NS | Write strobe per slave |
| slv_addr | output | NS*ADDR_W | Window offset per slave |
| slv_wdata | output | NS*DATA_W | Write data per slave |
| slv_rdata | input | NS*DATA_W | Read data from each slave |

## Verification
The bench builds the fabric with an 8-bit address and a 16-bit datum. Slave 0 gets a 16-word window at 0x00 and slave 1 a 32-word window at 0x40; the rest of the space is unmapped. Slave 0 waits 1 cycle on reads and 2 on writes, slave 1 waits 0 and 3, and `RD_LAT` is 2. With only 256 addresses, every one can be read and written, so each window edge, each wait count and the unmapped path are all covered by the sweep. The zero read wait of slave 1 makes a burst of back-to-back reads possible that mixes mapped and unmapped targets, which exposes any error in ordering or in the valid strobe.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  localparam int NS    = 2;
  localparam int TGT_W = $clog2(NS + 1);
endpackage

// File: rtl/mmx_decode.sv
module mmx_decode import mmx_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int unsigned BASE [NS] = '{32'h0000, 32'h1000},
  parameter int unsigned SZ   [NS] = '{8, 10}
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NS-1:0]        hit_o,
  output logic [NS*ADDR_W-1:0] off_o,
  output logic [TGT_W-1:0]     tgt_o
);
  for (genvar i = 0; i < NS; i++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE[i]);
    localparam logic [ADDR_W-1:0] MASK   = ADDR_W'((64'd1 << SZ[i]) - 64'd1);
    assign hit_o[i] = (addr_i & ~MASK) == (BASE_V & ~MASK);
    assign off_o[i*ADDR_W +: ADDR_W] = addr_i & MASK;
  end

  // target index, NS meaning no window matched
  always_comb begin
    tgt_o = TGT_W'(NS);
    for (int i = NS - 1; i >= 0; i--) begin
      if (hit_o[i]) tgt_o = TGT_W'(i);
    end
  end
endmodule

// File: rtl/mmx_waitgen.sv
module mmx_waitgen #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             wait_o,
  output logic             acc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wait_o = req_i && (cnt_q < lim_i);
  assign acc_o  = req_i && !wait_o;

  always_comb begin
    cnt_en = req_i;
    cnt_d  = wait_o ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mmx_rdpipe.sv
module mmx_rdpipe import mmx_pkg::*; #(
  parameter int LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic             vld_o,
  output logic [TGT_W-1:0] tgt_o
);
  logic [LAT-1:0]   v_q, v_d;
  logic [TGT_W-1:0] t_q [LAT];
  logic [TGT_W-1:0] t_d [LAT];

  always_comb begin
    v_d[0] = push_i;
    t_d[0] = tgt_i;
    for (int k = 1; k < LAT; k++) begin
      v_d[k] = v_q[k-1];
      t_d[k] = t_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < LAT; k++) t_q[k] <= '0;
    end else begin
      v_q <= v_d;
      for (int k = 0; k < LAT; k++) t_q[k] <= t_d[k];
    end
  end

  assign vld_o = v_q[LAT-1];
  assign tgt_o = t_q[LAT-1];
endmodule

// File: rtl/mmx_fabric.sv
module mmx_fabric import mmx_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int unsigned BASE    [NS] = '{32'h0000, 32'h1000},
  parameter int unsigned SZ      [NS] = '{8, 10},
  parameter int unsigned RD_WAIT [NS] = '{1, 0},
  parameter int unsigned WR_WAIT [NS] = '{2, 1},
  parameter int RD_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    m_addr,
  input  logic                 m_read,
  input  logic                 m_write,
  input  logic [DATA_W-1:0]    m_wdata,
  output logic [DATA_W-1:0]    m_rdata,
  output logic                 m_wait,
  output logic                 m_rdv,
  output logic [NS-1:0]        slv_sel,
  output logic [NS-1:0]        slv_rd,
  output logic [NS-1:0]        slv_wr,
  output logic [NS*ADDR_W-1:0] slv_addr,
  output logic [NS*DATA_W-1:0] slv_wdata,
  input  logic [NS*DATA_W-1:0] slv_rdata
);
  function automatic int max_wait();
    int m;
    m = 0;
    for (int i = 0; i < NS; i++) begin
      if (int'(RD_WAIT[i]) > m) m = int'(RD_WAIT[i]);
      if (int'(WR_WAIT[i]) > m) m = int'(WR_WAIT[i]);
    end
    return m;
  endfunction

  localparam int MAXW  = max_wait();
  localparam int CNT_W = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

  logic [NS-1:0]    hit;
  logic [TGT_W-1:0] tgt, ret_tgt;
  logic [CNT_W-1:0] lim;
  logic             acc, ret_vld;

  mmx_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SZ(SZ)) u_dec (
    .addr_i (m_addr),
    .hit_o  (hit),
    .off_o  (slv_addr),
    .tgt_o  (tgt)
  );

  // stall budget of the addressed slave for the current direction
  always_comb begin
    lim = '0;
    for (int i = 0; i < NS; i++) begin
      if (tgt == TGT_W'(i)) lim = m_write ? CNT_W'(WR_WAIT[i]) : CNT_W'(RD_WAIT[i]);
    end
  end

  mmx_waitgen #(.CNT_W(CNT_W)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (m_read | m_write),
    .lim_i  (lim),
    .wait_o (m_wait),
    .acc_o  (acc)
  );

  mmx_rdpipe #(.LAT(RD_LAT)) u_rpipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (acc & m_read & ~m_write),
    .tgt_i  (tgt),
    .vld_o  (ret_vld),
    .tgt_o  (ret_tgt)
  );

  for (genvar i = 0; i < NS; i++) begin : g_slv
    assign slv_sel[i] = hit[i];
    assign slv_rd[i]  = hit[i] & m_read;
    assign slv_wr[i]  = hit[i] & m_write;
    assign slv_wdata[i*DATA_W +: DATA_W] = hit[i] ? m_wdata : '0;
  end

  // return path: unmapped reads and idle cycles yield zero
  always_comb begin
    m_rdata = '0;
    for (int i = 0; i < NS; i++) begin
      if (ret_vld && ret_tgt == TGT_W'(i)) m_rdata = slv_rdata[i*DATA_W +: DATA_W];
    end
  end

  assign m_rdv = ret_vld;
endmodule

// File: rtl/mmx_fabric_chk.sv
module mmx_fabric_chk import mmx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int MAXW   = 2,
  parameter int RD_LAT = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 m_read,
  input logic                 m_write,
  input logic                 m_wait,
  input logic                 m_rdv,
  input logic [DATA_W-1:0]    m_rdata,
  input logic [NS-1:0]        slv_sel,
  input logic [NS-1:0]        slv_rd,
  input logic [NS-1:0]        slv_wr,
  input logic [NS*DATA_W-1:0] slv_wdata
);
  localparam int RUN_W = $clog2(MAXW + 2);
  localparam int OUT_W = $clog2(RD_LAT + 2);

  logic [RUN_W-1:0] wrun;
  logic [OUT_W-1:0] outst;
  logic             quiet_ok;
  logic             rd_take;

  assign rd_take = m_read & ~m_write & ~m_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrun  <= '0;
      outst <= '0;
    end else begin
      wrun  <= m_wait ? wrun + 1'b1 : '0;
      outst <= outst + OUT_W'(rd_take) - OUT_W'(m_rdv);
    end
  end

  always_comb begin
    quiet_ok = 1'b1;
    for (int i = 0; i < NS; i++) begin
      if (!slv_sel[i] && slv_wdata[i*DATA_W +: DATA_W] != '0) quiet_ok = 1'b0;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(slv_sel)); // R1
  AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n) ((slv_rd | slv_wr) & ~slv_sel) == '0); // R1
  AST_WDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n) quiet_ok); // R3
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) m_wait |-> (int'(wrun) < MAXW)); // R5
  AST_RDV_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) m_rdv |-> (outst != '0)); // R6
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !m_rdv |-> (m_rdata == '0)); // R7
  AST_MISS_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) ((m_read | m_write) && slv_sel == '0) |-> !m_wait); // R8
endmodule

bind mmx_fabric mmx_fabric_chk #(.DATA_W(DATA_W), .MAXW(MAXW), .RD_LAT(RD_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_read    (m_read),
  .m_write   (m_write),
  .m_wait    (m_wait),
  .m_rdv     (m_rdv),
  .m_rdata   (m_rdata),
  .slv_sel   (slv_sel),
  .slv_rd    (slv_rd),
  .slv_wr    (slv_wr),
  .slv_wdata (slv_wdata)
);

// File: tb/mmx_fabric_test.sv
module mmx_fabric_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] m_addr;
  logic          m_read, m_write;
  logic [DW-1:0] m_wdata, m_rdata;
  logic          m_wait, m_rdv;
  logic [1:0]    slv_sel, slv_rd, slv_wr;
  logic [2*AW-1:0] slv_addr;
  logic [2*DW-1:0] slv_wdata, slv_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mmx_fabric #(
    .ADDR_W(AW), .DATA_W(DW),
    .BASE('{32'h00, 32'h40}), .SZ('{4, 5}),
    .RD_WAIT('{1, 0}), .WR_WAIT('{2, 3}), .RD_LAT(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_read(m_read), .m_write(m_write),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_wait(m_wait), .m_rdv(m_rdv),
    .slv_sel(slv_sel), .slv_rd(slv_rd), .slv_wr(slv_wr), .slv_addr(slv_addr),
    .slv_wdata(slv_wdata), .slv_rdata(slv_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // slave models: data = tag | offset seen two cycles earlier
  logic [AW-1:0] sa1 [2];
  logic [AW-1:0] sa2 [2];
  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      sa1[i] <= slv_addr[i*AW +: AW];
      sa2[i] <= sa1[i];
    end
  end
  assign slv_rdata = {16'hD000 | 16'(sa2[1]), 16'hC000 | 16'(sa2[0])};

  function automatic int tgt_of(int a);
    if (a < 16) return 0;
    if (a >= 64 && a < 96) return 1;
    return 2;
  endfunction
  function automatic int off_of(int a);
    return (tgt_of(a) == 0) ? a : a - 64;
  endfunction
  function automatic int sel_of(int a);
    return (tgt_of(a) < 2) ? (1 << tgt_of(a)) : 0;
  endfunction
  function automatic int rdat_of(int a);
    if (tgt_of(a) == 0) return 32'hC000 | off_of(a);
    if (tgt_of(a) == 1) return 32'hD000 | off_of(a);
    return 0;
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic do_read(input int a);
    int n;
    int t;
    t = tgt_of(a);
    n = 0;
    @(negedge clk);
    m_addr = AW'(a); m_read = 1'b1;
    #1;
    while (m_wait && n < 20) begin
      n++;
      @(negedge clk); #1;
    end
    chk(n == ((t == 0) ? 1 : 0), "R5", "read waits", n, (t == 0) ? 1 : 0);
    chk(int'(slv_sel) == sel_of(a), (t < 2) ? "R1" : "R8", "read select", int'(slv_sel), sel_of(a));
    chk(int'(slv_rd) == sel_of(a) && slv_wr == 2'b00, "R1", "read strobes", int'(slv_rd), sel_of(a));
    if (t < 2) chk(int'(slv_addr[t*AW +: AW]) == off_of(a), "R2", "offset", int'(slv_addr[t*AW +: AW]), off_of(a));
    @(negedge clk);
    m_read = 1'b0;
    #1;
    chk(m_rdv == 1'b0, "R6", "valid early", int'(m_rdv), 0);
    chk(m_rdata == '0, "R7", "idle data", int'(m_rdata), 0);
    @(negedge clk); #1;
    chk(m_rdv == 1'b1, "R6", "valid at latency", int'(m_rdv), 1);
    chk(int'(m_rdata) == rdat_of(a), (t < 2) ? "R4" : "R8", "read data", int'(m_rdata), rdat_of(a));
  endtask

  task automatic do_write(input int a);
    int n;
    int t;
    int ew;
    logic [DW-1:0] wd;
    t = tgt_of(a);
    ew = (t == 0) ? 2 : (t == 1) ? 3 : 0;
    wd = 16'h5A00 ^ 16'(a * 3);
    n = 0;
    @(negedge clk);
    m_addr = AW'(a); m_write = 1'b1; m_wdata = wd;
    #1;
    while (m_wait && n < 20) begin
      n++;
      @(negedge clk); #1;
    end
    chk(n == ew, "R5", "write waits", n, ew);
    chk(int'(slv_wr) == sel_of(a) && slv_rd == 2'b00, (t < 2) ? "R1" : "R8", "write strobes", int'(slv_wr), sel_of(a));
    for (int i = 0; i < 2; i++) begin
      chk(slv_wdata[i*DW +: DW] == ((i == t) ? wd : '0), (t < 2) ? "R3" : "R8", "write data slot",
          int'(slv_wdata[i*DW +: DW]), (i == t) ? int'(wd) : 0);
    end
    @(negedge clk);
    m_write = 1'b0;
    #1;
    chk(m_rdv == 1'b0, "R6", "no valid after write", int'(m_rdv), 0);
  endtask

  initial begin
    int bad [4];
    int exp_d [4];
    bad = '{8'h40, 8'h80, 8'h5F, 8'h41};
    exp_d = '{32'hD000, 0, 32'hD01F, 32'hD001};
    rst_n = 1'b0; m_addr = '0; m_read = 1'b0; m_write = 1'b0; m_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(m_rdv == 1'b0, "R9", "valid in reset", int'(m_rdv), 0);
    chk(m_rdata == '0, "R9", "data in reset", int'(m_rdata), 0);
    chk(m_wait == 1'b0, "R9", "wait in reset", int'(m_wait), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 256; a++) do_read(a);
    for (int a = 0; a < 256; a++) do_write(a);

    // back-to-back reads mixing slave 1 and unmapped space
    repeat (3) @(negedge clk);
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j < 4) begin m_addr = AW'(bad[j]); m_read = 1'b1; end
      else m_read = 1'b0;
      #1;
      if (j < 4) chk(m_wait == 1'b0, "R6", "burst no stall", int'(m_wait), 0);
      chk(m_rdv == (j >= 2 && j < 6), "R6", "burst valid", int'(m_rdv), (j >= 2 && j < 6) ? 1 : 0);
      chk(int'(m_rdata) == ((j >= 2 && j < 6) ? exp_d[j-2] : 0), "R4", "burst order",
          int'(m_rdata), (j >= 2 && j < 6) ? exp_d[j-2] : 0);
    end

    // reset while a read is in flight
    @(negedge clk);
    m_addr = 8'h90; m_read = 1'b1;
    @(negedge clk);
    m_read = 1'b0; rst_n = 1'b0;
    #1;
    chk(m_rdv == 1'b0, "R9", "flushed valid", int'(m_rdv), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_rdv == 1'b0, "R9", "flushed after release", int'(m_rdv), 0);
    @(negedge clk); #1;
    chk(m_rdv == 1'b0, "R9", "no late return", int'(m_rdv), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule